// File: doc/BRIEF.md
# ADC Conversion Sequence Start Controller

This block decides the cycle in which an analog-to-digital converter begins a conversion sequence. A sequence can be launched by a software start strobe or by one external trigger pin. Two control bits choose how the pin is judged: as edges or as a level, and with either polarity. With the trigger disabled, a scan bit chooses between a single sequence per start and back-to-back sequences. The conversion engine reports the end of each sequence with a one-cycle completion pulse.

The trigger pin passes through a synchronizer of `SYNC_STAGES` flops before it is examined. Edges are found by comparing the newest synchronized sample with the one before it. The block drives a one-cycle start pulse and a busy level.

In edge mode, an extra active edge that arrives during a running sequence is not held for later. It only sets a sticky overrun flag, which stays set until it is cleared.

Top module: `adc_trig_seq_ctrl`

## Requirements
- R1: With `trig_en_i`=0 and `scan_i`=0, while idle, `seq_start_o` equals `sw_start_i`. When a sequence completes, no new sequence starts. The trigger pin has no effect.
- R2: With `trig_en_i`=0 and `scan_i`=1, a software start launches the first sequence. At every completion pulse, `seq_start_o` pulses in that same cycle, so sequences run back to back.
- R3: With `trig_en_i`=1 and `trig_level_i`=0, an idle block starts one sequence per active edge. The active edge is falling when `trig_pol_i`=0 and rising when `trig_pol_i`=1. A pin change captured at clock edge k gives the start pulse in the cycle after edge k+`SYNC_STAGES`-1.
- R4: With `trig_en_i`=1 and `trig_level_i`=1, the active level is low when `trig_pol_i`=0 and high when `trig_pol_i`=1. An idle block starts a sequence whenever the synchronized trigger is at its active level. If the level is still active in a completion cycle, the next sequence starts in that same cycle.
- R5: With `trig_en_i`=1, `sw_start_i` never causes a start.
- R6: `busy_o` rises the clock after `seq_start_o`. It stays high until the clock after `seq_done_i`, unless a restart occurs in that cycle. While idle, `seq_done_i` has no effect.
- R7: In edge mode, an active edge that arrives while `busy_o`=1 sets `ovr_o` on the next clock. It causes no start and is not queued for after the current sequence.
- R8: In level mode, trigger activity never sets `ovr_o`, even if the trigger deasserts and reasserts during a sequence.
- R9: `ovr_o` resets to 0. It stays set until `ovr_clr_i` is high at a clock edge. When a set and a clear fall in the same cycle, the set wins.
- R10: A change of the mode bits while busy does not end the running sequence. The next start decision, including a restart in the completion cycle, uses the settings present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_start_i | input | 1 | Software start strobe |
| scan_i | input | 1 | 1: back-to-back sequences when the trigger is disabled |
| trig_en_i | input | 1 | 1: only the external trigger may start sequences |
| trig_level_i | input | 1 | 1: level-sensitive trigger, 0: edge-sensitive trigger |
| trig_pol_i | input | 1 | 1: rising edge / active high, 0: falling edge / active low |
| trig_pin_i | input | 1 | Asynchronous external trigger pin |
| seq_done_i | input | 1 | One-cycle sequence-complete pulse from the converter |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| seq_start_o | output | 1 | One-cycle sequence start pulse |
| busy_o | output | 1 | A sequence is in progress |
| ovr_o | output | 1 | Sticky trigger overrun flag |

## Verification
Two functions can fall in the same cycle: a completion pulse and a new start decision. A restart can come from scan mode or from a level that is still active, and an edge can arrive in the completion cycle itself. A second collision is an overrun set meeting a clear. The bench provokes both by running a small stand-in converter with sequence lengths of 3 to 6 cycles. Against it, the bench toggles the pin, the software strobe and the clear in a pseudo-random pattern, across all sixteen settings of the mode bits and then with mode bits that change during sequences. Each cycle, the start, busy and overrun outputs are compared with a cycle model built from the requirements.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic [1:0] {
    MODE_SW_ONCE = 2'd0,
    MODE_SW_SCAN = 2'd1,
    MODE_EDGE    = 2'd2,
    MODE_LEVEL   = 2'd3
  } start_mode_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic cur_o,
  output logic prev_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[LAST];
    end
  end

  assign cur_o  = chain_q[LAST];
  assign prev_o = prev_q;
endmodule

// File: rtl/adc_trig_detect.sv
module adc_trig_detect (
  input  logic cur_i,
  input  logic prev_i,
  input  logic pol_i,
  output logic act_o,
  output logic edge_o
);
  logic act_prev;

  // polarity folds falling/low into the same active-high view
  assign act_o    = pol_i ? cur_i  : ~cur_i;
  assign act_prev = pol_i ? prev_i : ~prev_i;
  assign edge_o   = act_o & ~act_prev;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_trig_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  start_mode_e mode_i,
  input  logic        sw_start_i,
  input  logic        edge_evt_i,
  input  logic        trig_act_i,
  input  logic        done_i,
  output logic        start_o,
  output logic        busy_o
);
  logic busy_q;

  always_comb begin
    start_o = 1'b0;
    if (!busy_q) begin
      unique case (mode_i)
        MODE_SW_ONCE, MODE_SW_SCAN: start_o = sw_start_i;
        MODE_EDGE:                  start_o = edge_evt_i;
        MODE_LEVEL:                 start_o = trig_act_i;
        default:                    start_o = 1'b0;
      endcase
    end else if (done_i) begin
      // restart in the completion cycle
      start_o = (mode_i == MODE_SW_SCAN) || ((mode_i == MODE_LEVEL) && trig_act_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= start_o | (busy_q & ~done_i);
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/adc_ovr_flag.sv
module adc_ovr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_mode_i,
  input  logic edge_evt_i,
  input  logic busy_i,
  input  logic clr_i,
  output logic ovr_o
);
  logic ovr_q;
  logic set;

  assign set = edge_mode_i & edge_evt_i & busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ovr_q <= 1'b0;
    else if (set)   ovr_q <= 1'b1;
    else if (clr_i) ovr_q <= 1'b0;
  end

  assign ovr_o = ovr_q;
endmodule

// File: rtl/adc_trig_seq_ctrl.sv
module adc_trig_seq_ctrl
  import adc_trig_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_start_i,
  input  logic scan_i,
  input  logic trig_en_i,
  input  logic trig_level_i,
  input  logic trig_pol_i,
  input  logic trig_pin_i,
  input  logic seq_done_i,
  input  logic ovr_clr_i,
  output logic seq_start_o,
  output logic busy_o,
  output logic ovr_o
);
  start_mode_e mode;
  logic        pin_cur, pin_prev;
  logic        trig_act, edge_evt;

  always_comb begin
    if (trig_en_i) mode = trig_level_i ? MODE_LEVEL : MODE_EDGE;
    else           mode = scan_i ? MODE_SW_SCAN : MODE_SW_ONCE;
  end

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (trig_pin_i),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  adc_trig_detect u_detect (
    .cur_i  (pin_cur),
    .prev_i (pin_prev),
    .pol_i  (trig_pol_i),
    .act_o  (trig_act),
    .edge_o (edge_evt)
  );

  adc_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .sw_start_i (sw_start_i),
    .edge_evt_i (edge_evt),
    .trig_act_i (trig_act),
    .done_i     (seq_done_i),
    .start_o    (seq_start_o),
    .busy_o     (busy_o)
  );

  adc_ovr_flag u_ovr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_mode_i (mode == MODE_EDGE),
    .edge_evt_i  (edge_evt),
    .busy_i      (busy_o),
    .clr_i       (ovr_clr_i),
    .ovr_o       (ovr_o)
  );
endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scan_i,
  input logic trig_en_i,
  input logic trig_level_i,
  input logic seq_done_i,
  input logic ovr_clr_i,
  input logic seq_start_o,
  input logic busy_o,
  input logic ovr_o,
  input logic edge_evt_i
);
  a_r6_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_o |=> busy_o);

  a_r6_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !seq_done_i) |=> busy_o);

  a_r6_no_start_midseq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !seq_done_i) |-> !seq_start_o);

  a_r1_no_restart_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_en_i && !scan_i && busy_o && seq_done_i) |-> !seq_start_o);

  a_r2_scan_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_en_i && scan_i && busy_o && seq_done_i) |-> seq_start_o);

  a_r7_edge_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_en_i && !trig_level_i && busy_o && edge_evt_i) |=> ovr_o);

  a_r8_level_no_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_en_i && trig_level_i && !ovr_o) |=> !ovr_o);

  a_r9_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
endmodule

bind adc_trig_seq_ctrl adc_trig_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scan_i       (scan_i),
  .trig_en_i    (trig_en_i),
  .trig_level_i (trig_level_i),
  .seq_done_i   (seq_done_i),
  .ovr_clr_i    (ovr_clr_i),
  .seq_start_o  (seq_start_o),
  .busy_o       (busy_o),
  .ovr_o        (ovr_o),
  .edge_evt_i   (edge_evt)
);

// File: tb/tb_adc_trig_seq_ctrl.sv
module tb_adc_trig_seq_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_start_i = 0, scan_i = 0, trig_en_i = 0, trig_level_i = 0, trig_pol_i = 0;
  logic trig_pin_i = 0, seq_done_i = 0, ovr_clr_i = 0;
  logic seq_start_o, busy_o, ovr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // cycle model state
  logic m_p0 = 0, m_p1 = 0, m_prev = 0, m_busy = 0, m_ovr = 0;
  int   m_cnt = 0;
  int   seq_len = 3;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk_i = ~clk_i;

  adc_trig_seq_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sw_start_i(sw_start_i), .scan_i(scan_i),
    .trig_en_i(trig_en_i), .trig_level_i(trig_level_i), .trig_pol_i(trig_pol_i),
    .trig_pin_i(trig_pin_i), .seq_done_i(seq_done_i), .ovr_clr_i(ovr_clr_i),
    .seq_start_o(seq_start_o), .busy_o(busy_o), .ovr_o(ovr_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  // one cycle: drive at negedge, compare before posedge, advance model at posedge
  task automatic cycle(input bit mix_modes);
    logic act, actp, edg, st, nbusy, novr;
    string st_tag, ov_tag;
    int ncnt;
    @(negedge clk_i);
    step_lfsr();
    if (lfsr[2:0] == 3'd0) trig_pin_i = ~trig_pin_i;
    sw_start_i = (lfsr[7:5] == 3'd0);
    ovr_clr_i  = (lfsr[12:9] == 4'd0);
    if (mix_modes && lfsr[15:12] == 4'd5)
      {scan_i, trig_en_i, trig_level_i, trig_pol_i} = lfsr[11:8];
    // stand-in converter; spurious done while idle
    seq_done_i = m_busy ? (m_cnt == seq_len - 1) : (lfsr[4:3] == 2'd3);
    #5;
    act  = trig_pol_i ? m_p1 : ~m_p1;
    actp = trig_pol_i ? m_prev : ~m_prev;
    edg  = act & ~actp;
    if (!m_busy) begin
      if (!trig_en_i)         st = sw_start_i;
      else if (!trig_level_i) st = edg;
      else                    st = act;
    end else if (seq_done_i) begin
      st = (!trig_en_i && scan_i) || (trig_en_i && trig_level_i && act);
    end else st = 1'b0;
    nbusy = st | (m_busy & ~seq_done_i);
    novr  = (trig_en_i && !trig_level_i && edg && m_busy) ? 1'b1 : (m_ovr & ~ovr_clr_i);
    ncnt  = st ? 0 : (m_busy ? m_cnt + 1 : m_cnt);
    if (mix_modes)          begin st_tag = "R10 start"; ov_tag = "R10 R9 ovr"; end
    else if (!trig_en_i)    begin st_tag = scan_i ? "R2 start" : "R1 start"; ov_tag = "R9 ovr"; end
    else if (!trig_level_i) begin st_tag = "R3 R5 start"; ov_tag = "R7 R9 ovr"; end
    else                    begin st_tag = "R4 R5 start"; ov_tag = "R8 R9 ovr"; end
    chk(st_tag, seq_start_o, st);
    chk("R6 busy", busy_o, m_busy);
    chk(ov_tag, ovr_o, m_ovr);
    @(posedge clk_i);
    m_prev = m_p1; m_p1 = m_p0; m_p0 = trig_pin_i;
    m_busy = nbusy; m_ovr = novr; m_cnt = ncnt;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // reset state (R6, R9)
    chk("R6 reset busy", busy_o, 1'b0);
    chk("R9 reset ovr", ovr_o, 1'b0);
    chk("R1 reset start", seq_start_o, 1'b0);
    rst_ni = 1'b1;
    for (int cfg = 0; cfg < 16; cfg++) begin
      {scan_i, trig_en_i, trig_level_i, trig_pol_i} = cfg[3:0];
      seq_len = 3 + (cfg % 4);
      for (int i = 0; i < 300; i++) cycle(1'b0);
    end
    seq_len = 4;
    for (int i = 0; i < 1500; i++) cycle(1'b1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule